// File: doc/BRIEF.md
# Console Signalling Receiver with Keepalive Supervision

This block terminates the console-to-exchange direction of a serial signalling link. It recovers asynchronous characters from the line, which runs at 2.4 kbit/s. Each character is checked for framing, even line parity and an alternating sequence bit. Every message in this direction is a single byte. Within that byte, one bit alternates between messages, one bit is a parity bit that software checks later, and six bits carry key information. The block treats the byte as opaque apart from the sequence bit.

Each accepted byte is held in an output latch with a valid flag. A parallel-to-serial stage reads the latch and acknowledges with a one-cycle strobe.

A live console sends at least one character every 137 ms. A supervision counter measures the time since the last correctly framed character. When the window expires, the counter raises a link-fault flag so that the system can treat the console as lost.

Top module: `sig_rx_keepalive`

## Requirements
- R1: Reset state:
  - `rx_valid`, `par_err`, `seq_err` and `link_fault` are 0 during and after reset.
  - The line input idles high.
- R2: Character format and oversampling:
  - A character is one low start bit, 8 data bits sent LSB first, one parity bit and one high stop bit.
  - Each bit lasts 16*TICK_DIV clock cycles.
  - The line is sampled once every TICK_DIV cycles, and each bit is taken at its middle.
- R3: Start-bit filtering:
  - A low pulse on the idle line is treated as noise when it is no longer low at the middle of the start bit.
  - Such a pulse latches nothing, and the next proper character is received correctly.
- R4: Framing errors: a character whose stop bit samples low is discarded. It leaves `rx_byte`, `rx_valid`, `par_err` and `seq_err` unchanged.
- R5: Line parity:
  - The parity bit must make the count of ones over the 8 data bits plus parity even.
  - A framed character that fails this check sets `par_err`, is not latched, and leaves the sequence state unchanged.
  - `par_err` and `seq_err` always describe the most recent framed character.
- R6: Sequence bit:
  - Bit 7 of the byte is the sequence bit.
  - A framed, parity-correct byte whose bit 7 equals that of the last accepted byte sets `seq_err` and is not latched.
  - The first byte after reset, and the first byte after a link fault, is accepted whatever its sequence bit.
- R7: Acceptance: an accepted byte appears on `rx_byte` with `rx_valid` high, and both `par_err` and `seq_err` read 0.
- R8: Read strobe:
  - A `rd_strobe` pulse clears `rx_valid` on the next edge and leaves `rx_byte` unchanged.
  - If an acceptance happens in the same cycle, the acceptance wins.
- R9: Overwrite: a newly accepted byte replaces an unread one, and `rx_valid` stays high.
- R10: Fault detection: `link_fault` rises once FAULT_CYCLES clock cycles pass with no correctly framed character.
- R11: Fault recovery:
  - `link_fault` clears on the first correctly framed character after a fault, even one with a parity error.
  - That character also restarts the supervision window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 1 | Serial line from the console, idle high |
| rd_strobe | input | 1 | One-cycle read acknowledge from the parallel-to-serial stage |
| rx_byte | output | 8 | Last accepted message byte |
| rx_valid | output | 1 | Latch holds an unread byte |
| par_err | output | 1 | Last framed character failed line parity |
| seq_err | output | 1 | Last framed character repeated the sequence bit |
| link_fault | output | 1 | No framed character within the keepalive window |

## Verification
The assertions assume the following about the inputs:
- Reset is applied in the first cycle.
- The line holds each bit for a whole bit period and returns high between characters.
- The read strobe may arrive in any cycle.

The stimulus drives the line from a task aligned to the clock, with exact bit periods and idle gaps. It pulses the strobe for one cycle. It keeps every gap between characters inside the shortened supervision window, except where a fault is meant to occur. Glitch and framing-fault cases still leave the line high before the next start bit.

// File: rtl/sig_rx_keepalive.sv
module sig_rx_keepalive #(
  parameter int TICK_DIV     = 48,
  parameter int FAULT_CYCLES = 252518,
  parameter int SEQ_BIT      = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_in,
  input  logic       rd_strobe,
  output logic [7:0] rx_byte,
  output logic       rx_valid,
  output logic       par_err,
  output logic       seq_err,
  output logic       link_fault
);

  localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int FW = $clog2(FAULT_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} rx_state_t;

  rx_state_t     state;
  logic [1:0]    sync_q;
  logic [TW-1:0] div_cnt;
  logic [3:0]    ph_cnt;
  logic [2:0]    bit_cnt;
  logic [7:0]    shreg;
  logic          pbit;
  logic          framed;
  logic          seq_known;
  logic          last_seq;
  logic [FW-1:0] wd_cnt;

  wire line   = sync_q[1];
  wire tick   = (div_cnt == TW'(TICK_DIV - 1));
  wire par_ok = (pbit == ^shreg);
  wire seq_ok = !seq_known || (shreg[SEQ_BIT] != last_seq);
  wire accept = framed && par_ok && seq_ok;
  wire wd_exp = !framed && (wd_cnt == FW'(FAULT_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q  <= 2'b11;
      div_cnt <= '0;
    end else begin
      sync_q  <= {sync_q[0], line_in};
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      ph_cnt  <= '0;
      bit_cnt <= '0;
      shreg   <= '0;
      pbit    <= 1'b0;
      framed  <= 1'b0;
    end else begin
      framed <= 1'b0;
      if (tick) begin
        unique case (state)
          S_IDLE: if (!line) begin
            state  <= S_START;
            ph_cnt <= '0;
          end
          S_START: if (ph_cnt == 4'd7) begin
            ph_cnt  <= '0;
            bit_cnt <= '0;
            state   <= line ? S_IDLE : S_DATA;
          end else ph_cnt <= ph_cnt + 1'b1;
          S_DATA: if (ph_cnt == 4'd15) begin
            ph_cnt <= '0;
            shreg  <= {line, shreg[7:1]};
            if (bit_cnt == 3'd7) state <= S_PAR;
            else bit_cnt <= bit_cnt + 1'b1;
          end else ph_cnt <= ph_cnt + 1'b1;
          S_PAR: if (ph_cnt == 4'd15) begin
            ph_cnt <= '0;
            pbit   <= line;
            state  <= S_STOP;
          end else ph_cnt <= ph_cnt + 1'b1;
          S_STOP: if (ph_cnt == 4'd15) begin
            ph_cnt <= '0;
            state  <= S_IDLE;
            framed <= line;
          end else ph_cnt <= ph_cnt + 1'b1;
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_byte    <= '0;
      rx_valid   <= 1'b0;
      par_err    <= 1'b0;
      seq_err    <= 1'b0;
      seq_known  <= 1'b0;
      last_seq   <= 1'b0;
      link_fault <= 1'b0;
      wd_cnt     <= '0;
    end else begin
      if (framed) begin
        par_err <= !par_ok;
        seq_err <= par_ok && !seq_ok;
      end
      if (accept) begin
        rx_byte   <= shreg;
        last_seq  <= shreg[SEQ_BIT];
        seq_known <= 1'b1;
        rx_valid  <= 1'b1;
      end else if (rd_strobe) begin
        rx_valid  <= 1'b0;
      end
      if (framed) begin
        wd_cnt     <= '0;
        link_fault <= 1'b0;
      end else if (wd_exp) begin
        link_fault <= 1'b1;
        seq_known  <= 1'b0;
      end else begin
        wd_cnt <= wd_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sig_rx_keepalive_chk.sv
module sig_rx_keepalive_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_strobe,
  input logic       framed,
  input logic       accept,
  input logic [7:0] rx_byte,
  input logic       rx_valid,
  input logic       par_err,
  input logic       seq_err,
  input logic       link_fault
);

  a_r7_accept_clean: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rx_valid && !par_err && !seq_err);

  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe && !accept |=> !rx_valid);

  a_r4_byte_held: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(rx_byte));

  a_r5_flags_held: assert property (@(posedge clk) disable iff (!rst_n)
    !framed |=> $stable(par_err) && $stable(seq_err));

  a_r11_fault_clears: assert property (@(posedge clk) disable iff (!rst_n)
    framed |=> !link_fault);

  a_r10_fault_holds: assert property (@(posedge clk) disable iff (!rst_n)
    link_fault && !framed |=> link_fault);

endmodule

bind sig_rx_keepalive sig_rx_keepalive_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .framed(framed),
  .accept(accept), .rx_byte(rx_byte), .rx_valid(rx_valid),
  .par_err(par_err), .seq_err(seq_err), .link_fault(link_fault)
);

// File: tb/tb_sig_rx_keepalive.sv
module tb_sig_rx_keepalive;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int FAULT      = 6000;
  localparam int BIT_CLK    = 16 * TICK_DIV;

  logic clk = 0, rst_n = 0, line_in = 1, rd_strobe = 0;
  logic [7:0] rx_byte;
  logic rx_valid, par_err, seq_err, link_fault;
  int checks = 0, errors = 0;
  bit finished = 0;

  sig_rx_keepalive #(.TICK_DIV(TICK_DIV), .FAULT_CYCLES(FAULT)) dut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .rd_strobe(rd_strobe),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .par_err(par_err),
    .seq_err(seq_err), .link_fault(link_fault));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input bit b);
    @(posedge clk) line_in <= b;
    repeat (BIT_CLK - 1) @(posedge clk);
  endtask

  task automatic send_char(input logic [7:0] d, input bit good_par, input bit good_stop);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    drive_bit(good_par ? ^d : ~^d);
    drive_bit(good_stop);
    drive_bit(1'b1);
    @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(!rx_valid && !par_err && !seq_err && !link_fault, "R1 reset",
        {rx_valid, par_err, seq_err, link_fault}, 0);
    @(posedge clk) rst_n <= 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!rx_valid && !link_fault, "R1 after reset", {rx_valid, link_fault}, 0);
  endtask

  task automatic t_glitch;
    @(posedge clk) line_in <= 0;
    repeat (12) @(posedge clk);
    line_in <= 1;
    repeat (BIT_CLK * 2) @(posedge clk);
    @(negedge clk);
    chk(!rx_valid, "R3 glitch ignored", rx_valid, 0);
  endtask

  task automatic t_first;
    send_char(8'h15, 1, 1);
    chk(rx_valid && rx_byte == 8'h15, "R2 first byte", rx_byte, 8'h15);
    chk(!par_err && !seq_err, "R7 flags clear", {par_err, seq_err}, 0);
  endtask

  task automatic t_parity;
    send_char(8'h96, 0, 1);
    chk(par_err, "R5 parity flag", par_err, 1);
    chk(rx_byte == 8'h15, "R5 not latched", rx_byte, 8'h15);
    send_char(8'h93, 1, 1);
    chk(rx_byte == 8'h93 && !par_err, "R5 seq state kept", rx_byte, 8'h93);
  endtask

  task automatic t_sequence;
    send_char(8'h9A, 1, 1);
    chk(seq_err && !par_err, "R6 repeat flagged", {seq_err, par_err}, 2);
    chk(rx_byte == 8'h93, "R6 not latched", rx_byte, 8'h93);
    send_char(8'h2C, 1, 1);
    chk(rx_byte == 8'h2C && !seq_err, "R6 toggle accepted", rx_byte, 8'h2C);
  endtask

  task automatic t_read;
    @(posedge clk) rd_strobe <= 1;
    @(posedge clk) rd_strobe <= 0;
    @(negedge clk);
    chk(!rx_valid, "R8 strobe clears", rx_valid, 0);
    chk(rx_byte == 8'h2C, "R8 byte held", rx_byte, 8'h2C);
  endtask

  task automatic t_framing;
    send_char(8'hC3, 1, 0);
    repeat (BIT_CLK) @(posedge clk);
    @(negedge clk);
    chk(!rx_valid && rx_byte == 8'h2C, "R4 dropped", rx_byte, 8'h2C);
    chk(!par_err && !seq_err, "R4 flags unchanged", {par_err, seq_err}, 0);
  endtask

  task automatic t_overwrite;
    send_char(8'hA1, 1, 1);
    send_char(8'h42, 1, 1);
    chk(rx_valid && rx_byte == 8'h42, "R9 overwrite", rx_byte, 8'h42);
  endtask

  task automatic t_fault;
    repeat (FAULT - 300) @(posedge clk);
    @(negedge clk);
    chk(!link_fault, "R10 before window", link_fault, 0);
    repeat (500) @(posedge clk);
    @(negedge clk);
    chk(link_fault, "R10 fault raised", link_fault, 1);
    send_char(8'h05, 1, 1);
    chk(!link_fault, "R11 fault cleared", link_fault, 0);
    chk(rx_byte == 8'h05 && !seq_err, "R6 accepted after fault", rx_byte, 8'h05);
  endtask

  task automatic t_fault_parity;
    repeat (FAULT + 200) @(posedge clk);
    @(negedge clk);
    chk(link_fault, "R10 second fault", link_fault, 1);
    send_char(8'h81, 0, 1);
    chk(!link_fault && par_err, "R11 cleared by bad parity", {link_fault, par_err}, 1);
    repeat (FAULT - 300) @(posedge clk);
    @(negedge clk);
    chk(!link_fault, "R11 window restarted", link_fault, 0);
  endtask

  initial begin
    t_reset();
    t_glitch();
    t_first();
    t_parity();
    t_sequence();
    t_read();
    t_framing();
    t_overwrite();
    t_fault();
    t_fault_parity();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule